// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides one 32-bit integer by another and returns both quotient and remainder. Each operation treats the operands as either two's-complement or unsigned values, chosen by an input. A single-cycle start pulse captures the operands. A one-cycle done pulse then presents the results, and they stay on the outputs until the next operation completes. Only one divide is in flight at a time. While it runs, busy is high and further start pulses are discarded.

Latency depends on the operands. A preparation cycle takes the operand magnitudes and counts their leading zeros. It then aligns the dividend so that only the significant quotient bits are iterated. Each radix-4 step retires two quotient bits, and two steps are chained in every clock. A final cycle applies the signs. Division by zero, the single signed overflow case and any dividend smaller in magnitude than the divisor are all settled in the preparation cycle. Under the default parameters no divide takes more than 10 cycles, well inside a 14-cycle budget.

Top module: `idiv_early`

## Requirements
- R1: After a synchronous active-low reset, busy, done, div_zero and overflow are 0 and quotient and remainder are all zeros.
- R2: With is_signed=0 and a non-zero divisor, quotient is the unsigned floor of dividend/divisor and remainder is dividend minus quotient times divisor.
- R3: With is_signed=1, the quotient magnitude is |dividend|/|divisor| truncated. It is negated when exactly one operand is negative. The remainder has the dividend's sign and a magnitude below |divisor|.
- R4: With a non-zero divisor, |dividend| >= |divisor| and no overflow, done rises on the edge L = 2 + ceil((clz(|divisor|) - clz(|dividend|) + 1) / 4). Edges are counted from the one that samples start (edge 0), and clz is the count of leading zeros in the 32-bit magnitude.
- R5: No operation takes more than 10 edges from start to done, which is within 14.
- R6: With a non-zero divisor and |dividend| < |divisor|, done rises at L = 1 with quotient 0 and remainder equal to the dividend.
- R7: A zero divisor gives done at L = 1, quotient all ones, remainder equal to the dividend and div_zero = 1, in either mode. div_zero is 0 after any other operation.
- R8: With is_signed=1, 0x80000000 divided by 0xFFFFFFFF gives done at L = 1, quotient 0x80000000, remainder 0 and overflow = 1. In unsigned mode the same pair is an ordinary divide with overflow = 0.
- R9: busy is 1 from the edge that samples start until the edge that raises done, and done lasts exactly one cycle. Quotient, remainder and the flags hold until the next completion.
- R10: A start pulse while busy is 1 is ignored. The running divide completes with its own operands and latency, and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a divide |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 32 | Dividend, captured with start |
| divisor | input | 32 | Divisor, captured with start |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed divide |
| remainder | output | 32 | Remainder of the last completed divide |
| div_zero | output | 1 | Last divide had a zero divisor |
| overflow | output | 1 | Last divide was the signed overflow case |

## Verification
The bench pins the latency formula at both extremes. A divisor of magnitude 1 against a full-width dividend must take 10 edges, and equal-magnitude operands must take 3. A design that iterated a fixed count, or padded the quotient bits wrongly, would miss one of these edges and could also drop the top quotient digit. Every combination of operand signs is exercised, including the most negative dividend. Wrong sign handling shows up as a positive quotient for mixed signs, or a remainder whose sign follows the divisor. The divide-by-zero, overflow and small-dividend shortcuts are each checked for their one-edge latency and exact outputs. A start pulse injected mid-operation must neither restart the work nor queue a second result.

// File: rtl/idiv_pkg.sv
// Package idiv_pkg
// Types shared by the iterative divider: controller states and the
// result classes that the preparation logic decides between.
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIX  = 2'd3
    } idiv_state_e;

    typedef enum logic [1:0] {
        RK_NORMAL = 2'd0,
        RK_ZERO   = 2'd1,
        RK_OVF    = 2'd2,
        RK_SMALL  = 2'd3
    } idiv_kind_e;

endpackage

// File: rtl/idiv_clz.sv
// Module idiv_clz
// Counts leading zeros of a W-bit vector; an all-zero input yields W.
// Assumes nothing about the input; purely combinational.
module idiv_clz #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);

    // Priority scan: the highest set bit sets the count last.
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/idiv_prep.sv
// Module idiv_prep
// Combinational preparation for one divide: operand magnitudes, sign
// decisions, special-case class and the aligned starting state for
// the radix-4 iteration. Assumes W is a multiple of BPC (quotient bits
// retired per clock) and that the alignment is used only for RK_NORMAL.
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int W     = 32,
    parameter int BPC   = 4,
    parameter int CNT_W = 4
) (
    input  logic             sgn,
    input  logic [W-1:0]     dvd,
    input  logic [W-1:0]     dvs,
    output logic [W-1:0]     b_mag,
    output logic             neg_quo,
    output logic             neg_rem,
    output idiv_kind_e       kind,
    output logic [CNT_W-1:0] n_iter,
    output logic [W-1:0]     p_init,
    output logic [W-1:0]     a_init
);

    localparam int CW = $clog2(W) + 1;

    logic          neg_a;
    logic          neg_b;
    logic [W-1:0]  a_mag;
    logic [CW-1:0] clz_a;
    logic [CW-1:0] clz_b;
    logic [2*W-1:0] ext;
    int            k_int;
    int            n_int;
    int            sh_int;

    // Magnitudes and result signs from the operand sign bits.
    always_comb begin
        neg_a   = sgn & dvd[W-1];
        neg_b   = sgn & dvs[W-1];
        a_mag   = neg_a ? (~dvd + 1'b1) : dvd;
        b_mag   = neg_b ? (~dvs + 1'b1) : dvs;
        neg_quo = neg_a ^ neg_b;
        neg_rem = neg_a;
    end

    idiv_clz #(.W(W), .CW(CW)) i_clz_a (.vec(a_mag), .zeros(clz_a));
    idiv_clz #(.W(W), .CW(CW)) i_clz_b (.vec(b_mag), .zeros(clz_b));

    // Special-case classification, zero divisor taking priority.
    always_comb begin
        if (dvs == '0) begin
            kind = RK_ZERO;
        end else if (sgn && (dvd == {1'b1, {(W-1){1'b0}}}) && (dvs == '1)) begin
            kind = RK_OVF;
        end else if (a_mag < b_mag) begin
            kind = RK_SMALL;
        end else begin
            kind = RK_NORMAL;
        end
    end

    // Quotient bit count padded to whole clocks, then dividend alignment.
    always_comb begin
        k_int = int'(clz_b) - int'(clz_a);
        if (k_int < 0) begin
            k_int = 0;
        end
        n_int  = (k_int + BPC) / BPC;
        sh_int = W - n_int * BPC;
        ext    = {{W{1'b0}}, a_mag} << sh_int;
        p_init = ext[2*W-1:W];
        a_init = ext[W-1:0];
        n_iter = CNT_W'(n_int);
    end

endmodule

// File: rtl/idiv_r4_stage.sv
// Module idiv_r4_stage
// One radix-4 restoring step: shifts two dividend bits into the partial
// remainder, picks the largest digit d in 0..3 with d*b <= remainder,
// subtracts it and appends d to the quotient. Assumes p_in < b.
module idiv_r4_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] b,
    output logic [W-1:0] p_out,
    output logic [W-1:0] a_out,
    output logic [W-1:0] q_out
);

    localparam int XW = W + 2;

    logic [XW-1:0] p4;
    logic [XW-1:0] b1;
    logic [XW-1:0] b2;
    logic [XW-1:0] b3;
    logic [XW-1:0] sub;
    logic [XW-1:0] diff;
    logic [1:0]    digit;

    // Digit selection against the three divisor multiples in parallel.
    always_comb begin
        p4 = {p_in, a_in[W-1:W-2]};
        b1 = {2'b00, b};
        b2 = {1'b0, b, 1'b0};
        b3 = b1 + b2;
        if (p4 >= b3) begin
            digit = 2'd3;
            sub   = b3;
        end else if (p4 >= b2) begin
            digit = 2'd2;
            sub   = b2;
        end else if (p4 >= b1) begin
            digit = 2'd1;
            sub   = b1;
        end else begin
            digit = 2'd0;
            sub   = '0;
        end
        diff  = p4 - sub;
        p_out = diff[W-1:0];
        a_out = {a_in[W-3:0], 2'b00};
        q_out = {q_in[W-3:0], digit};
    end

endmodule

// File: rtl/idiv_early.sv
// Module idiv_early
// Iterative signed/unsigned divider with leading-zero skipping.
// Edge 0 captures the operands; the PREP cycle either finishes a special
// case or loads the aligned state; ITER runs STEPS radix-4 stages per
// clock; FIX applies the signs and raises done. One divide at a time.
module idiv_early
    import idiv_pkg::*;
#(
    parameter int W     = 32,
    parameter int STEPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero,
    output logic         overflow
);

    localparam int BPC     = 2 * STEPS;
    localparam int NMAX    = W / BPC;
    localparam int CNT_W   = $clog2(NMAX + 1);
    localparam int MAX_LAT = NMAX + 2;
    localparam int LAT_W   = $clog2(MAX_LAT + 2) + 1;

    idiv_state_e      state;
    logic [W-1:0]     op_a;
    logic [W-1:0]     op_b;
    logic             op_sgn;
    logic [W-1:0]     p_q;
    logic [W-1:0]     a_q;
    logic [W-1:0]     q_acc;
    logic [W-1:0]     b_q;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_quo_q;
    logic             neg_rem_q;
    logic [LAT_W-1:0] lat_cnt;

    logic [W-1:0]     pre_bmag;
    logic             pre_negq;
    logic             pre_negr;
    idiv_kind_e       pre_kind;
    logic [CNT_W-1:0] pre_n;
    logic [W-1:0]     pre_p;
    logic [W-1:0]     pre_a;

    logic [W-1:0] p_ch [STEPS+1];
    logic [W-1:0] a_ch [STEPS+1];
    logic [W-1:0] q_ch [STEPS+1];

    assign busy = (state != ST_IDLE);

    idiv_prep #(.W(W), .BPC(BPC), .CNT_W(CNT_W)) i_prep (
        .sgn     (op_sgn),
        .dvd     (op_a),
        .dvs     (op_b),
        .b_mag   (pre_bmag),
        .neg_quo (pre_negq),
        .neg_rem (pre_negr),
        .kind    (pre_kind),
        .n_iter  (pre_n),
        .p_init  (pre_p),
        .a_init  (pre_a)
    );

    assign p_ch[0] = p_q;
    assign a_ch[0] = a_q;
    assign q_ch[0] = q_acc;

    // Chain of radix-4 stages evaluated within one clock.
    for (genvar g = 0; g < STEPS; g++) begin : g_stage
        idiv_r4_stage #(.W(W)) i_stage (
            .p_in  (p_ch[g]),
            .a_in  (a_ch[g]),
            .q_in  (q_ch[g]),
            .b     (b_q),
            .p_out (p_ch[g+1]),
            .a_out (a_ch[g+1]),
            .q_out (q_ch[g+1])
        );
    end

    // Controller and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_a      <= '0;
            op_b      <= '0;
            op_sgn    <= 1'b0;
            p_q       <= '0;
            a_q       <= '0;
            q_acc     <= '0;
            b_q       <= '0;
            cnt_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_a   <= dividend;
                        op_b   <= divisor;
                        op_sgn <= is_signed;
                        state  <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    case (pre_kind)
                        RK_ZERO: begin
                            quotient  <= '1;
                            remainder <= op_a;
                            div_zero  <= 1'b1;
                            overflow  <= 1'b0;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end
                        RK_OVF: begin
                            quotient  <= op_a;
                            remainder <= '0;
                            div_zero  <= 1'b0;
                            overflow  <= 1'b1;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end
                        RK_SMALL: begin
                            quotient  <= '0;
                            remainder <= op_a;
                            div_zero  <= 1'b0;
                            overflow  <= 1'b0;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end
                        default: begin
                            p_q       <= pre_p;
                            a_q       <= pre_a;
                            q_acc     <= '0;
                            b_q       <= pre_bmag;
                            cnt_q     <= pre_n;
                            neg_quo_q <= pre_negq;
                            neg_rem_q <= pre_negr;
                            state     <= ST_ITER;
                        end
                    endcase
                end
                ST_ITER: begin
                    p_q   <= p_ch[STEPS];
                    a_q   <= a_ch[STEPS];
                    q_acc <= q_ch[STEPS];
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state <= ST_FIX;
                    end
                end
                default: begin
                    quotient  <= neg_quo_q ? (~q_acc + 1'b1) : q_acc;
                    remainder <= neg_rem_q ? (~p_q + 1'b1) : p_q;
                    div_zero  <= 1'b0;
                    overflow  <= 1'b0;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // Edges elapsed since the accepting edge, for the latency cap check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (!busy && start) begin
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R9
    AST_LATENCY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt >= LAT_W'(1) && lat_cnt <= LAT_W'(MAX_LAT))); // R5
    AST_DZ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1 && !overflow));        // R7
    AST_OVF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (remainder == '0 && !div_zero));       // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_a) && $stable(op_b)));        // R10
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER) |-> (p_q < b_q));                          // R2

endmodule

// File: tb/test_idiv_early.sv
// Directed bench for idiv_early: one task per scenario, each checking
// its own results against a reference computed here.
module test_idiv_early;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_LAT    = 10;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic        is_signed;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic        busy;
    logic        done;
    logic [31:0] quotient;
    logic [31:0] remainder;
    logic        div_zero;
    logic        overflow;

    int checks;
    int failures;
    int max_seen;

    idiv_early i_idiv_early (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int clz32(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return 31 - i;
        end
        return 32;
    endfunction

    // Reference model built from the requirements.
    task automatic ref_div(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                           output logic [31:0] q, output logic [31:0] r,
                           output logic dz, output logic ov, output int lat);
        logic [31:0] am;
        logic [31:0] bm;
        dz = 1'b0;
        ov = 1'b0;
        am = (sgn && a[31]) ? -a : a;
        bm = (sgn && b[31]) ? -b : b;
        if (b == 32'd0) begin
            q = 32'hFFFF_FFFF; r = a; dz = 1'b1; lat = 1;
        end else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h8000_0000; r = 32'd0; ov = 1'b1; lat = 1;
        end else if (am < bm) begin
            q = 32'd0; r = a; lat = 1;
        end else begin
            if (sgn) begin
                q = 32'($signed(a) / $signed(b));
                r = 32'($signed(a) % $signed(b));
            end else begin
                q = a / b;
                r = a % b;
            end
            lat = 2 + (clz32(bm) - clz32(am) + 4) / 4;
        end
    endtask

    // Runs one divide, measuring edges to done and checking busy on the way.
    task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                           input logic sgn, input string req);
        logic [31:0] eq;
        logic [31:0] er;
        logic        edz;
        logic        eov;
        int          elat;
        int          lat;
        logic        busy_ok;
        ref_div(a, b, sgn, eq, er, edz, eov, elat);
        @(negedge clk);
        dividend = a; divisor = b; is_signed = sgn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_ok = busy;
        lat = 0;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
        end
        if (lat > max_seen) max_seen = lat;
        chk(req, "quotient", quotient, eq);
        chk(req, "remainder", remainder, er);
        chk("R7", "div_zero", 32'(div_zero), 32'(edz));
        chk("R8", "overflow", 32'(overflow), 32'(eov));
        chk("R4", "latency", 32'(lat), 32'(elat));
        chk("R9", "busy until done", {31'd0, busy_ok & ~busy}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "quotient", quotient, 32'd0);
        chk("R1", "remainder", remainder, 32'd0);
        chk("R1", "flags", {30'd0, div_zero, overflow}, 32'd0);
    endtask

    task automatic t_unsigned();
        run_div(32'd100, 32'd7, 1'b0, "R2");
        run_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R2");
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2");
        run_div(32'h1234_5678, 32'h0000_1234, 1'b0, "R2");
        run_div(32'hDEAD_BEEF, 32'h0000_0010, 1'b0, "R2");
    endtask

    task automatic t_signed();
        run_div(-32'sd100, 32'sd7, 1'b1, "R3");
        run_div(32'sd100, -32'sd7, 1'b1, "R3");
        run_div(-32'sd100, -32'sd7, 1'b1, "R3");
        run_div(32'h8000_0000, 32'd1, 1'b1, "R3");
        run_div(32'h8000_0000, 32'h8000_0000, 1'b1, "R3");
        run_div(32'h7FFF_FFFF, -32'sd3, 1'b1, "R3");
    endtask

    task automatic t_small();
        run_div(32'd5, 32'd9, 1'b0, "R6");
        run_div(-32'sd3, 32'sd10, 1'b1, "R6");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R6");
    endtask

    task automatic t_divzero();
        run_div(32'd1234, 32'd0, 1'b0, "R7");
        run_div(-32'sd5, 32'd0, 1'b1, "R7");
    endtask

    task automatic t_overflow();
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8");
        run_div(32'd9, 32'd3, 1'b1, "R8");
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        dividend = 32'hFFFF_FFFF; divisor = 32'd3; is_signed = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin
            @(negedge clk);
            lat++;
        end
        dividend = 32'd10; divisor = 32'd2; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R10", "latency kept", 32'(lat), 32'd10);
        chk("R10", "quotient kept", quotient, 32'h5555_5555);
        chk("R10", "remainder kept", remainder, 32'd0);
        @(negedge clk);
        chk("R10", "no second op busy", 32'(busy), 32'd0);
        chk("R9", "done one cycle", 32'(done), 32'd0);
        @(negedge clk);
        chk("R9", "result held", quotient, 32'h5555_5555);
        chk("R10", "no second done", 32'(done), 32'd0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0; failures = 0; max_seen = 0;
        rst_n = 1'b0; start = 1'b0; is_signed = 1'b0;
        dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_small();
        t_divzero();
        t_overflow();
        t_busy_ignore();
        chk("R5", "max latency within cap", {31'd0, max_seen <= MAX_LAT}, 32'd1);
        chk("R5", "worst case reached", 32'(max_seen), 32'(MAX_LAT));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule